// File: doc/BRIEF.md
# PCI Bus Parity Checker and Error Reporter

This block sits next to one PCI bus port of a bridge and watches the shared AD, C/BE and PAR lines on every clock. For each address phase, and for each data phase whose data the bridge receives, it waits one clock for the matching PAR. It then checks even parity over all 37 lines. A bad address tells the target decoder not to claim the transaction, so that the transaction ends in master abort. A bad address can also drive the system error line. A bad data phase can drive the data parity error line, and on a read mastered by the bridge it asks the master state machine to abort. When the bridge supplies read data, the block produces the PAR value for the following clock.

Both error lines are open-drain. Each is modelled as a level output paired with an active-high output enable: the line is driven low while the enable is high and is released otherwise. Three sticky status flags record what was seen. Each flag is cleared by a write-one pulse on its own bit of the clear input. The bridge's bus sequencer supplies phase strobes that are already qualified by FRAME#, IRDY# and TRDY#, so idle cycles and wait states are never checked.

Top module: `pci_parity_guard`

## Requirements
- R1: When `rd_drive_i` is high in cycle k, `par_oe_o` is high in cycle k+1 and `par_o` equals the XOR of the 32 AD bits and 4 C/BE bits of cycle k, which makes the total count of ones even. `par_oe_o` is low in every other cycle.
- R2: An `addr_phase_i` strobe in cycle k is checked against `par_i` in cycle k+1. On a mismatch, `no_claim_o` is high combinationally in cycle k+1 and stays high until the cycle after the next address strobe. Address strobes are at least two cycles apart.
- R3: An address parity error from a strobe in cycle k drives `serr_oe_o` high and `serr_n_o` low for cycle k+2 only. This happens only if `perr_resp_i` and `serr_en_i` are both high in cycle k+1. Otherwise the line stays released.
- R4: A `data_phase_i` strobe is checked only when the bridge is target of a write (`master_i`=0, `write_i`=1) or master of a read (`master_i`=1, `write_i`=0). Strobes with the other two role and direction pairs never raise an error.
- R5: A checked data phase in cycle k with a parity mismatch in cycle k+1 drives `perr_oe_o` high and `perr_n_o` low for cycle k+2 only, and only if `perr_resp_i` is high in cycle k+1.
- R6: A parity mismatch on a data phase where the bridge is master of a read pulses `mabort_req_o` in cycle k+2, whatever the enable bits are.
- R7: `det_perr_o` becomes set in cycle k+2 after any detected address or checked data parity error, whatever the enable bits are.
- R8: `sig_serr_o` becomes set together with every SERR# drive. `mdpe_o` becomes set in cycle k+2 after a master read data parity error while `perr_resp_i` is high in cycle k+1.
- R9: `clr_i` bit 0 clears `det_perr_o`, bit 1 clears `sig_serr_o` and bit 2 clears `mdpe_o`, taking effect at the next clock edge. A new set event in the same cycle wins over the clear.
- R10: While `rst_ni` is low, all strobes, enables and sticky flags are low, both error lines are released (`*_n_o` high), and `no_claim_o` is low.
- R11: Cycles with no phase strobe never cause an error, whatever the values on AD, C/BE and PAR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ad_i | input | 32 | Sampled AD lines |
| cbe_i | input | 4 | Sampled C/BE lines |
| par_i | input | 1 | Sampled PAR line |
| addr_phase_i | input | 1 | Address phase strobe (first FRAME# clock) |
| data_phase_i | input | 1 | Data transfer strobe (IRDY# and TRDY# both low) |
| write_i | input | 1 | Current transaction is a write |
| master_i | input | 1 | Bridge is master of the current transaction |
| rd_drive_i | input | 1 | Bridge drives read data on AD this cycle |
| perr_resp_i | input | 1 | Parity error response enable (command bit 6) |
| serr_en_i | input | 1 | System error enable (command bit 8) |
| clr_i | input | 3 | Write-one clear for the sticky flags |
| par_o | output | 1 | Generated PAR value |
| par_oe_o | output | 1 | PAR output enable |
| serr_n_o | output | 1 | SERR# drive level |
| serr_oe_o | output | 1 | SERR# output enable |
| perr_n_o | output | 1 | PERR# drive level |
| perr_oe_o | output | 1 | PERR# output enable |
| no_claim_o | output | 1 | Tells the target decoder to withhold DEVSEL# |
| mabort_req_o | output | 1 | Master abort request to the master state machine |
| det_perr_o | output | 1 | Sticky: parity error detected |
| sig_serr_o | output | 1 | Sticky: system error signalled |
| mdpe_o | output | 1 | Sticky: master data parity error |

## Verification
A corrupt capture stage, such as a stale parity sum or a wrong role qualifier, first shows on `no_claim_o` in the cycle after the phase. It reaches the error strobes, `mabort_req_o` and the sticky flags one clock later. A report stage that fails to clear leaves a strobe high for a second cycle, and a bad clear shows as a flag that stays set on the next clock. Every cycle compares all outputs with a cycle-accurate model, so any such fault shows within two clocks of the stimulus that exposes it.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;
  localparam int unsigned CLR_DET  = 0;
  localparam int unsigned CLR_SERR = 1;
  localparam int unsigned CLR_MDPE = 2;
  localparam int unsigned CLR_W    = 3;

  typedef struct packed {
    logic xsum;     // XOR of AD and C/BE from previous cycle
    logic addr;     // previous cycle was an address phase
    logic dchk;     // previous cycle was a checked data phase
    logic mrd;      // previous cycle was a master read data phase
  } chk_stage_t;
endpackage

// File: rtl/ppc_capture.sv
module ppc_capture
  import pci_par_pkg::*;
#(
  parameter int unsigned AD_W = 32,
  parameter int unsigned BE_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AD_W-1:0]  ad_i,
  input  logic [BE_W-1:0]  cbe_i,
  input  logic             addr_phase_i,
  input  logic             data_phase_i,
  input  logic             write_i,
  input  logic             master_i,
  output logic             xsum_o,
  output chk_stage_t       stage_o
);
  localparam int unsigned BUS_W = AD_W + BE_W;

  logic [BUS_W-1:0] bus;
  logic             tgt_wr, mst_rd;

  assign bus    = {ad_i, cbe_i};
  assign xsum_o = ^bus;
  assign tgt_wr = !master_i &&  write_i;
  assign mst_rd =  master_i && !write_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_o <= '0;
    end else begin
      stage_o.xsum <= xsum_o;
      stage_o.addr <= addr_phase_i;
      stage_o.dchk <= data_phase_i && (tgt_wr || mst_rd);
      stage_o.mrd  <= data_phase_i && mst_rd;
    end
  end
endmodule

// File: rtl/ppc_pargen.sv
module ppc_pargen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic xsum_i,
  input  logic rd_drive_i,
  output logic par_o,
  output logic par_oe_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      par_o    <= 1'b0;
      par_oe_o <= 1'b0;
    end else begin
      par_oe_o <= rd_drive_i;
      if (rd_drive_i) par_o <= xsum_i;
    end
  end
endmodule

// File: rtl/ppc_report.sv
module ppc_report
  import pci_par_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  chk_stage_t       stage_i,
  input  logic             par_i,
  input  logic             addr_phase_i,
  input  logic             perr_resp_i,
  input  logic             serr_en_i,
  input  logic [CLR_W-1:0] clr_i,
  output logic             serr_oe_o,
  output logic             perr_oe_o,
  output logic             no_claim_o,
  output logic             mabort_req_o,
  output logic             det_perr_o,
  output logic             sig_serr_o,
  output logic             mdpe_o
);
  logic par_bad, addr_err, data_err, serr_set, mdpe_set;
  logic hold_q;

  assign par_bad  = stage_i.xsum ^ par_i;
  assign addr_err = stage_i.addr && par_bad;
  assign data_err = stage_i.dchk && par_bad;
  assign serr_set = addr_err && perr_resp_i && serr_en_i;
  assign mdpe_set = data_err && stage_i.mrd && perr_resp_i;

  // suppress DEVSEL# immediately; keep it until a new address phase
  assign no_claim_o = addr_err || hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      serr_oe_o    <= 1'b0;
      perr_oe_o    <= 1'b0;
      mabort_req_o <= 1'b0;
      hold_q       <= 1'b0;
      det_perr_o   <= 1'b0;
      sig_serr_o   <= 1'b0;
      mdpe_o       <= 1'b0;
    end else begin
      serr_oe_o    <= serr_set;
      perr_oe_o    <= data_err && perr_resp_i;
      mabort_req_o <= data_err && stage_i.mrd;
      hold_q       <= addr_err || (hold_q && !addr_phase_i);
      det_perr_o   <= (det_perr_o && !clr_i[CLR_DET])  || addr_err || data_err;
      sig_serr_o   <= (sig_serr_o && !clr_i[CLR_SERR]) || serr_set;
      mdpe_o       <= (mdpe_o     && !clr_i[CLR_MDPE]) || mdpe_set;
    end
  end
endmodule

// File: rtl/pci_parity_guard.sv
module pci_parity_guard
  import pci_par_pkg::*;
#(
  parameter int unsigned AD_W = 32,
  parameter int unsigned BE_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AD_W-1:0]  ad_i,
  input  logic [BE_W-1:0]  cbe_i,
  input  logic             par_i,
  input  logic             addr_phase_i,
  input  logic             data_phase_i,
  input  logic             write_i,
  input  logic             master_i,
  input  logic             rd_drive_i,
  input  logic             perr_resp_i,
  input  logic             serr_en_i,
  input  logic [CLR_W-1:0] clr_i,
  output logic             par_o,
  output logic             par_oe_o,
  output logic             serr_n_o,
  output logic             serr_oe_o,
  output logic             perr_n_o,
  output logic             perr_oe_o,
  output logic             no_claim_o,
  output logic             mabort_req_o,
  output logic             det_perr_o,
  output logic             sig_serr_o,
  output logic             mdpe_o
);
  chk_stage_t stage;
  logic       xsum;

  ppc_capture #(.AD_W(AD_W), .BE_W(BE_W)) i_capture (
    .clk_i, .rst_ni, .ad_i, .cbe_i, .addr_phase_i, .data_phase_i,
    .write_i, .master_i, .xsum_o(xsum), .stage_o(stage)
  );

  ppc_pargen i_pargen (
    .clk_i, .rst_ni, .xsum_i(xsum), .rd_drive_i, .par_o, .par_oe_o
  );

  ppc_report i_report (
    .clk_i, .rst_ni, .stage_i(stage), .par_i, .addr_phase_i,
    .perr_resp_i, .serr_en_i, .clr_i, .serr_oe_o, .perr_oe_o,
    .no_claim_o, .mabort_req_o, .det_perr_o, .sig_serr_o, .mdpe_o
  );

  // open-drain: level is low only while enabled
  assign serr_n_o = !serr_oe_o;
  assign perr_n_o = !perr_oe_o;
endmodule

// File: rtl/pci_parity_guard_chk.sv
module pci_parity_guard_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic addr_phase_i,
  input logic data_phase_i,
  input logic write_i,
  input logic master_i,
  input logic rd_drive_i,
  input logic perr_resp_i,
  input logic serr_en_i,
  input logic par_oe_o,
  input logic serr_oe_o,
  input logic perr_oe_o,
  input logic mabort_req_o,
  input logic sig_serr_o
);
  assert_pargen_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_oe_o |-> $past(rd_drive_i));
  assert_serr_src_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serr_oe_o |-> $past(addr_phase_i, 2));
  assert_serr_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serr_oe_o |-> $past(perr_resp_i && serr_en_i));
  assert_serr_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serr_oe_o |=> !serr_oe_o);
  assert_perr_src_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perr_oe_o |-> $past(data_phase_i && (master_i ? !write_i : write_i), 2));
  assert_perr_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perr_oe_o |-> $past(perr_resp_i));
  assert_mabort_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mabort_req_o |-> $past(data_phase_i && master_i && !write_i, 2));
  assert_sig_serr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sig_serr_o) |-> serr_oe_o);
endmodule

bind pci_parity_guard pci_parity_guard_chk i_chk (
  .clk_i, .rst_ni, .addr_phase_i, .data_phase_i, .write_i, .master_i,
  .rd_drive_i, .perr_resp_i, .serr_en_i, .par_oe_o, .serr_oe_o,
  .perr_oe_o, .mabort_req_o, .sig_serr_o
);

// File: tb/test_pci_parity_guard.sv
module test_pci_parity_guard;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] ad_i = '0;
  logic [3:0]  cbe_i = '0;
  logic        par_i = 1'b0, addr_phase_i = 1'b0, data_phase_i = 1'b0;
  logic        write_i = 1'b0, master_i = 1'b0, rd_drive_i = 1'b0;
  logic        perr_resp_i = 1'b0, serr_en_i = 1'b0;
  logic [2:0]  clr_i = '0;
  logic par_o, par_oe_o, serr_n_o, serr_oe_o, perr_n_o, perr_oe_o;
  logic no_claim_o, mabort_req_o, det_perr_o, sig_serr_o, mdpe_o;

  int checks = 0, errors = 0;

  // model state
  logic m_xor, m_addr, m_dchk, m_mrd, m_par, m_paroe;
  logic m_serr, m_perr, m_mab, m_hold, m_det, m_sig, m_mdpe;
  logic prev_addr;

  always #10 clk_i = ~clk_i;

  pci_parity_guard i_pci_parity_guard (.*);

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog R10: actual hung, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  function automatic logic even_par(input logic [31:0] a, input logic [3:0] b);
    return ^{a, b};
  endfunction

  task automatic model_reset();
    {m_xor, m_addr, m_dchk, m_mrd, m_par, m_paroe} = '0;
    {m_serr, m_perr, m_mab, m_hold, m_det, m_sig, m_mdpe} = '0;
    prev_addr = 1'b0;
  endtask

  // inputs are already applied; check outputs, then advance one clock
  task automatic step();
    logic aerr, derr, bad;
    logic n_xor, n_addr, n_dchk, n_mrd, n_serr, n_perr, n_mab, n_hold;
    logic n_det, n_sig, n_mdpe;
    #2;
    bad  = m_xor ^ par_i;
    aerr = m_addr & bad;
    derr = m_dchk & bad;
    chk("R1 par_oe", par_oe_o, m_paroe);
    if (m_paroe) chk("R1 par value", par_o, m_par);
    chk("R2 no_claim", no_claim_o, aerr | m_hold);
    chk("R3 serr_oe", serr_oe_o, m_serr);
    chk("R3 serr_n", serr_n_o, !m_serr);
    chk("R4 R5 perr_oe", perr_oe_o, m_perr);
    chk("R5 perr_n", perr_n_o, !m_perr);
    chk("R6 mabort", mabort_req_o, m_mab);
    chk("R7 R9 R11 det_perr", det_perr_o, m_det);
    chk("R8 R9 sig_serr", sig_serr_o, m_sig);
    chk("R8 R9 mdpe", mdpe_o, m_mdpe);
    n_xor  = even_par(ad_i, cbe_i);
    n_addr = addr_phase_i;
    n_dchk = data_phase_i & (master_i ? !write_i : write_i);
    n_mrd  = data_phase_i & master_i & !write_i;
    n_serr = aerr & perr_resp_i & serr_en_i;
    n_perr = derr & perr_resp_i;
    n_mab  = derr & m_mrd;
    n_hold = aerr | (m_hold & !addr_phase_i);
    n_det  = (m_det & !clr_i[0]) | aerr | derr;
    n_sig  = (m_sig & !clr_i[1]) | n_serr;
    n_mdpe = (m_mdpe & !clr_i[2]) | (derr & m_mrd & perr_resp_i);
    m_par = n_xor; m_paroe = rd_drive_i;
    @(posedge clk_i);
    m_xor = n_xor; m_addr = n_addr; m_dchk = n_dchk; m_mrd = n_mrd;
    m_serr = n_serr; m_perr = n_perr; m_mab = n_mab; m_hold = n_hold;
    m_det = n_det; m_sig = n_sig; m_mdpe = n_mdpe;
    prev_addr = addr_phase_i;
    @(negedge clk_i);
  endtask

  task automatic idle();
    addr_phase_i = 0; data_phase_i = 0; rd_drive_i = 0; clr_i = '0;
  endtask

  initial begin
    void'($urandom(32'h5eed_c0de));
    model_reset();
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk("R10 serr_n", serr_n_o, 1'b1);
    chk("R10 serr_oe", serr_oe_o, 1'b0);
    chk("R10 perr_n", perr_n_o, 1'b1);
    chk("R10 perr_oe", perr_oe_o, 1'b0);
    chk("R10 no_claim", no_claim_o, 1'b0);
    chk("R10 det", det_perr_o, 1'b0);
    chk("R10 mabort", mabort_req_o, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // directed R2/R3: bad address, both enables on
    perr_resp_i = 1; serr_en_i = 1; idle();
    ad_i = 32'h0000_0001; cbe_i = 4'h6; addr_phase_i = 1; step();
    idle(); par_i = 1'b0; step();   // correct would be 1
    par_i = 1'b0; step(); step(); step();
    // R3 enables partially off: only bit 8
    perr_resp_i = 0;
    ad_i = 32'h0000_0003; cbe_i = 4'h0; addr_phase_i = 1; step();
    idle(); par_i = 1'b1; step(); step(); step();
    // R9 clear all, with no set event
    clr_i = 3'b111; step(); idle(); step();
    // R6 master read error, enables off
    master_i = 1; write_i = 0;
    ad_i = 32'hFFFF_0000; cbe_i = 4'h1; data_phase_i = 1; step();
    idle(); par_i = 1'b0; step(); step(); step();
    // R4 target read ignored
    master_i = 0; data_phase_i = 1; step();
    idle(); par_i = ~par_i; step(); step(); step();
    // R11 idle cycles with garbage
    for (int i = 0; i < 20; i++) begin
      ad_i = $urandom; cbe_i = 4'($urandom); par_i = 1'($urandom); step();
    end

    // constrained random
    for (int i = 0; i < 6000; i++) begin
      idle();
      ad_i  = $urandom;
      cbe_i = 4'($urandom);
      if (!prev_addr && ($urandom % 4 == 0)) addr_phase_i = 1;
      else if ($urandom % 2 == 0) data_phase_i = 1;
      write_i     = 1'($urandom);
      master_i    = 1'($urandom);
      rd_drive_i  = 1'($urandom);
      perr_resp_i = ($urandom % 4 != 0);
      serr_en_i   = ($urandom % 4 != 0);
      if ($urandom % 8 == 0) clr_i = 3'($urandom);
      par_i = ($urandom % 4 == 0) ? !m_xor : m_xor;
      step();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule